// File: doc/BRIEF.md
# Coprocessor Hold and Reset Control Register

This block is a small register target that a host processor uses to hold a secondary 8-bit coprocessor. Writing the hold register drives the coprocessor's bus request line. Writing the reset register drives its reset line. A status byte at the hold offset tells the host when the coprocessor is both held off the bus and held in reset. Both control registers are active-on-zero: writing a zero byte asserts the line, and writing any nonzero byte releases it.

The host port is a plain synchronous register interface. It has an address, write data, a write strobe, a read strobe and registered read data, and it decodes a 16 KB window through a 14-bit offset. The ROM/DRAM mode offset is accepted but has no effect. Every other access is treated as unmapped, and the block answers it with a one-cycle error pulse. The port has no streaming data, so it has no valid/ready handshake. Every access completes in the cycle its strobe is high, and read data appears one cycle later.

Top module: `cop_ctrl`

## Requirements
- R1: After reset, `cop_busreq_o`, `cop_reset_o`, `rd_data_o` and `acc_err_o` are all 0.
- R2: A write to offset 0x100 sets `cop_busreq_o` to 1 at the next clock edge if the byte is 0x00, and to 0 if it is any other value.
- R3: A write to offset 0x200 sets `cop_reset_o` to 1 at the next clock edge if the byte is 0x00, and to 0 if it is any other value.
- R4: A read of offset 0x100 loads `rd_data_o` at the next edge. It loads 0x01 if both control lines were 1 in the read cycle, and 0x00 otherwise. `rd_data_o` holds its value until the next read.
- R5: A write to offset 0x000 (mode select) changes neither control line and raises no error.
- R6: A write to an unmapped offset changes neither control line. A read of an unmapped offset loads 0x00. Offsets 0x000 and 0x200 are unmapped for reads.
- R7: `acc_err_o` is 1 for exactly the cycle after an unmapped read or write, and 0 after any other cycle.
- R8: The control lines are register outputs and change only at the edge that follows a write strobe to their own offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 14 | Byte offset inside the 16 KB window |
| reg_wdata_i | input | 8 | Write data |
| reg_wr_i | input | 1 | Write strobe, one access per high cycle |
| reg_rd_i | input | 1 | Read strobe, one access per high cycle |
| rd_data_o | output | 8 | Registered read data, valid the cycle after a read |
| cop_busreq_o | output | 1 | Bus request line to the coprocessor, 1 = requested |
| cop_reset_o | output | 1 | Reset line to the coprocessor, 1 = held in reset |
| acc_err_o | output | 1 | One-cycle pulse after an unmapped access |

## Verification
The bench writes a nonzero byte to each control offset and checks that the line is released. A design that treated any write as an assertion would keep the line high. It then reads the status with only bus request held, which must return 0x00. A design that ORed the two lines would wrongly return 0x01. Near-miss offsets (0x101, 0x300, 0x3FFF), and reads of the write-only offsets 0x000 and 0x200, must raise the error pulse and leave the lines alone. A decoder that compared too few address bits would alias these onto a control register. The bench also checks that read data holds across idle cycles and that a mode write stays silent. A block that cleared read data when no read was active, or that flagged the mode offset as unmapped, would fail those checks.

// File: rtl/cop_pkg.sv
package cop_pkg;
  // Index of each control line inside the line vector
  localparam int unsigned LINE_BUSREQ = 0;
  localparam int unsigned LINE_RESET  = 1;
  localparam int unsigned NUM_LINES   = 2;

  typedef struct packed {
    logic [NUM_LINES-1:0] line_wr;  // write strobe aimed at a control line
    logic                 stat_rd;  // read of the status byte
    logic                 bad_acc;  // unmapped read or write
  } cop_dec_t;
endpackage

// File: rtl/cop_decode.sv
module cop_decode
  import cop_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned MODE_OFS = 'h000,
  parameter int unsigned BRQ_OFS  = 'h100,
  parameter int unsigned RST_OFS  = 'h200
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output cop_dec_t          dec_o
);
  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(BRQ_OFS);
  localparam logic [ADDR_W-1:0] LINE_A [NUM_LINES] = '{ADDR_W'(BRQ_OFS), ADDR_W'(RST_OFS)};

  logic [NUM_LINES-1:0] line_match;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign line_match[g] = (addr_i == LINE_A[g]);
  end

  logic wr_known;
  assign wr_known = (|line_match) || (addr_i == MODE_A);

  always_comb begin
    dec_o.line_wr = line_match & {NUM_LINES{wr_i}};
    dec_o.stat_rd = rd_i && (addr_i == STAT_A);
    dec_o.bad_acc = (wr_i && !wr_known) || (rd_i && (addr_i != STAT_A));
  end
endmodule

// File: rtl/cop_ctl_line.sv
module cop_ctl_line #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              line_o
);
  // Active on a written zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      line_o <= 1'b0;
    else if (load_i) line_o <= (wdata_i == '0);
  end
endmodule

// File: rtl/cop_status.sv
module cop_status #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic              stat_rd_i,
  input  logic              busreq_i,
  input  logic              reset_i,
  output logic [DATA_W-1:0] rd_data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_data_o <= '0;
    else if (rd_i)
      rd_data_o <= stat_rd_i ? DATA_W'(busreq_i && reset_i) : '0;
  end
endmodule

// File: rtl/cop_ctrl.sv
module cop_ctrl
  import cop_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MODE_OFS = 'h000,
  parameter int unsigned BRQ_OFS  = 'h100,
  parameter int unsigned RST_OFS  = 'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              cop_busreq_o,
  output logic              cop_reset_o,
  output logic              acc_err_o
);
  cop_dec_t             dec;
  logic [NUM_LINES-1:0] lines;

  cop_decode #(
    .ADDR_W(ADDR_W), .MODE_OFS(MODE_OFS), .BRQ_OFS(BRQ_OFS), .RST_OFS(RST_OFS)
  ) u_decode (
    .addr_i(reg_addr_i), .wr_i(reg_wr_i), .rd_i(reg_rd_i), .dec_o(dec)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_ctl
    cop_ctl_line #(.DATA_W(DATA_W)) u_line (
      .clk(clk), .rst_n(rst_n), .load_i(dec.line_wr[g]),
      .wdata_i(reg_wdata_i), .line_o(lines[g])
    );
  end

  assign cop_busreq_o = lines[LINE_BUSREQ];
  assign cop_reset_o  = lines[LINE_RESET];

  cop_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n), .rd_i(reg_rd_i), .stat_rd_i(dec.stat_rd),
    .busreq_i(lines[LINE_BUSREQ]), .reset_i(lines[LINE_RESET]),
    .rd_data_o(rd_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_err_o <= 1'b0;
    else        acc_err_o <= dec.bad_acc;
  end
endmodule

// File: rtl/cop_ctrl_chk.sv
module cop_ctrl_chk #(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MODE_OFS = 'h000,
  parameter int unsigned BRQ_OFS  = 'h100,
  parameter int unsigned RST_OFS  = 'h200
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              cop_busreq_o,
  input logic              cop_reset_o,
  input logic              acc_err_o
);
  logic at_brq, at_rst, at_mode, wr_odd, rd_odd;
  assign at_brq  = reg_addr_i == ADDR_W'(BRQ_OFS);
  assign at_rst  = reg_addr_i == ADDR_W'(RST_OFS);
  assign at_mode = reg_addr_i == ADDR_W'(MODE_OFS);
  assign wr_odd  = reg_wr_i && !(at_brq || at_rst || at_mode);
  assign rd_odd  = reg_rd_i && !at_brq;

  // R2
  brq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_i && at_brq |=> cop_busreq_o == ($past(reg_wdata_i) == '0));
  // R3
  rst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_i && at_rst |=> cop_reset_o == ($past(reg_wdata_i) == '0));
  // R4
  stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_i && at_brq |=> rd_data_o == DATA_W'($past(cop_busreq_o && cop_reset_o)));
  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_i |=> $stable(rd_data_o));
  // R5
  mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_i && at_mode && !reg_rd_i |=> !acc_err_o && $stable(cop_busreq_o) && $stable(cop_reset_o));
  // R6
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_odd |=> rd_data_o == '0);
  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_odd || rd_odd) |=> acc_err_o);
  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_odd || rd_odd) |=> !acc_err_o);
  // R8
  brq_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && at_brq) |=> $stable(cop_busreq_o));
  // R8
  rst_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && at_rst) |=> $stable(cop_reset_o));
endmodule

bind cop_ctrl cop_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_OFS(MODE_OFS), .BRQ_OFS(BRQ_OFS), .RST_OFS(RST_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .rd_data_o(rd_data_o),
  .cop_busreq_o(cop_busreq_o), .cop_reset_o(cop_reset_o), .acc_err_o(acc_err_o)
);

// File: tb/test_cop_ctrl.sv
`timescale 1ns/1ps
module test_cop_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [13:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic       reg_wr_i = 1'b0;
  logic       reg_rd_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       cop_busreq_o, cop_reset_o, acc_err_o;

  always #2.5 clk = ~clk;  // 200 MHz

  cop_ctrl i_cop_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .rd_data_o(rd_data_o),
    .cop_busreq_o(cop_busreq_o), .cop_reset_o(cop_reset_o), .acc_err_o(acc_err_o)
  );

  typedef struct {
    logic       brq;
    logic       rst;
    logic [7:0] rd;
    logic       err;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // Reference state built from the requirements
  logic       m_brq = 1'b0, m_rst = 1'b0;
  logic [7:0] m_rd  = 8'h00;

  function automatic void compare(exp_t e);
    n_chk++;
    if (cop_busreq_o !== e.brq || cop_reset_o !== e.rst || rd_data_o !== e.rd || acc_err_o !== e.err) begin
      n_bad++;
      $display("FAIL %s: got brq=%0b rst=%0b rd=%02h err=%0b, expected brq=%0b rst=%0b rd=%02h err=%0b",
               e.tag, cop_busreq_o, cop_reset_o, rd_data_o, acc_err_o, e.brq, e.rst, e.rd, e.err);
    end
  endfunction

  // Driver: one access per call; pushes the expected result of that access
  task automatic access(input bit wr, input bit rd, input logic [13:0] a,
                        input logic [7:0] d, input string tag);
    exp_t e;
    bit   bad;
    @(negedge clk);
    reg_wr_i = wr; reg_rd_i = rd; reg_addr_i = a; reg_wdata_i = d;
    bad = 1'b0;
    if (rd) begin
      m_rd = (a == 14'h100) ? {7'b0, m_brq & m_rst} : 8'h00;
      if (a != 14'h100) bad = 1'b1;
    end
    if (wr) begin
      if (a == 14'h100)      m_brq = (d == 8'h00);
      else if (a == 14'h200) m_rst = (d == 8'h00);
      else if (a != 14'h000) bad = 1'b1;
    end
    e.brq = m_brq; e.rst = m_rst; e.rd = m_rd; e.err = bad; e.tag = tag;
    @(posedge clk);
    exp_q.push_back(e);
  endtask

  // Monitor: compares each expected item one half cycle after its edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    r.brq = 0; r.rst = 0; r.rd = 8'h00; r.err = 0; r.tag = "R1 reset state";
    compare(r);
    rst_n = 1'b1;
    access(0, 1, 14'h100, 8'h00, "R4 status both low");
    access(1, 0, 14'h100, 8'h00, "R2 busreq assert");
    access(0, 1, 14'h100, 8'h00, "R4 status busreq only");
    access(1, 0, 14'h200, 8'h00, "R3 reset assert");
    access(0, 1, 14'h100, 8'h00, "R4 status both high");
    access(0, 0, 14'h000, 8'h00, "R8 idle, lines and rdata hold");
    access(0, 0, 14'h100, 8'h00, "R8 idle address at busreq, no strobe");
    access(1, 0, 14'h000, 8'h5A, "R5 mode write silent");
    access(1, 0, 14'h300, 8'h00, "R6 unmapped write, R7 err");
    access(1, 0, 14'h101, 8'h01, "R6 near-miss write, R7 err");
    access(0, 1, 14'h200, 8'h00, "R6 read of write-only reset offset");
    access(0, 1, 14'h100, 8'h00, "R4 status both high again");
    access(0, 1, 14'h3FFF, 8'h00, "R6 unmapped top read, R7 err");
    access(0, 1, 14'h000, 8'h00, "R6 read of mode offset");
    access(1, 0, 14'h100, 8'h01, "R2 busreq release");
    access(0, 1, 14'h100, 8'h00, "R4 status reset only");
    access(1, 0, 14'h200, 8'h80, "R3 reset release");
    access(1, 0, 14'h100, 8'h00, "R2 busreq assert again");
    access(1, 0, 14'h100, 8'hFF, "R2 busreq release on 0xFF");
    access(1, 0, 14'h2000, 8'h00, "R6 aliased-looking write, R7 err");
    access(0, 0, 14'h000, 8'h00, "R7 err drops after one cycle");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, expected end of stimulus");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule